// File: doc/BRIEF.md
# Flash Full-Chip Erase Sequencer

This block runs the complete erase procedure for a byte-wide flash array. It is started by a one-cycle `start` pulse and first brings every byte to zero. It does this by handing each address in turn to a separate byte program sequencer through a start/done handshake. It then applies erase pulses and checks the array one address at a time. A byte is accepted when it reads back as all ones. When a byte fails, the sequencer applies one more erase pulse and checks that same address again, then carries on from there. It does not go back to address zero.

All array accesses go through a shared bus-cycle request port, which an external arbiter also grants to the program sequencer. A request is held until the arbiter answers with `bus_ack`. The number of erase pulses is capped by a parameter. The run ends in one of three ways: pass, fail during preconditioning, or fail after the pulse cap is reached. In every case the high-voltage enable drops and the final address stays visible.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `pass`, `fail` and `vpp_en` are low, `fail_code` is 0, and neither `bus_req` nor `prog_start` is asserted.
- R2: After `start`, `prog_start` is pulsed for one cycle for each address from 0 to LAST_ADDR in ascending order. Each pulse after the first waits for the previous `prog_done`. No erase command is written before the last address has been preconditioned.
- R3: If `prog_done` arrives with `prog_fail` high, the run ends at once. `fail` becomes 1, `fail_code` becomes 2'b01, and `last_addr` holds the failing address. No erase command is issued.
- R4: Each erase pulse consists of two back-to-back bus writes of data 8'h20. After them no bus request is made for at least ERASE_CYC cycles.
- R5: Each verify writes 8'hA0 to the address under test. At least VERIFY_CYC idle cycles follow, and then the same address is read.
- R6: Verification starts at address 0. A read value of 8'hFF advances to the next address.
- R7: A read value other than 8'hFF causes a new erase pulse, and verification then resumes at that same address.
- R8: A mismatch seen after MAX_PULSES erase pulses ends the run. `fail` becomes 1, `fail_code` becomes 2'b10, `last_addr` holds the failing address, and no further bus request is made.
- R9: After LAST_ADDR verifies, one bus write of 8'h00 (read command) is issued. The run then ends with `pass` = 1 and `last_addr` = LAST_ADDR.
- R10: `vpp_en` is high while the run is in progress (whenever `bus_req` or `prog_start` is asserted) and low once the run has ended.
- R11: A bus request keeps `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` steady until the cycle in which `bus_ack` is seen.
- R12: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a full erase run |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Last run succeeded |
| fail | output | 1 | Last run failed |
| fail_code | output | 2 | 01 precondition failure, 10 pulse cap reached |
| last_addr | output | ADDR_W | Final address reached |
| vpp_en | output | 1 | High-voltage enable |
| prog_start | output | 1 | One-cycle request to program a byte to zero |
| prog_addr | output | ADDR_W | Byte address for the program sequencer |
| prog_done | input | 1 | Program sequencer finished |
| prog_fail | input | 1 | Program sequencer result was a failure (valid with prog_done) |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_wdata | output | 8 | Write data / command |
| bus_ack | input | 1 | Bus cycle completed (granted) |
| bus_rdata | input | 8 | Read data, valid with bus_ack |

## Verification
The hardest behaviour to reach is a resume in the middle of the scan. A late address must fail, the pulse that follows must fix it, and the scan must then continue from that address and not from zero. The bench's array model reaches this state by giving each address its own count of erase pulses needed before it reads as FFh. Each profile fixes the exact number of verify reads the design should make, and a restart from zero would show up as extra reads. One profile puts the stubborn byte past the pulse cap, so the run stops on the failure path at a known address.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int ADDR_W     = 16,
  parameter int LAST_ADDR  = 'hFFFF,
  parameter int MAX_PULSES = 1000,
  parameter int ERASE_CYC  = 500000,
  parameter int VERIFY_CYC = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              pass,
  output logic              fail,
  output logic [1:0]        fail_code,
  output logic [ADDR_W-1:0] last_addr,
  output logic              vpp_en,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  input  logic              prog_done,
  input  logic              prog_fail,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata
);
  localparam int TW = $clog2(ERASE_CYC + VERIFY_CYC + 1);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [ADDR_W-1:0] LAST = LAST_ADDR[ADDR_W-1:0];
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_VERIFY = 8'hA0;
  localparam logic [7:0] CMD_READ   = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_PREW, S_SET1, S_SET2, S_PULSE,
    S_VCMD, S_VWAIT, S_VRD, S_RDCMD
  } st_t;

  st_t              st;
  logic [ADDR_W-1:0] addr;
  logic [PW-1:0]     pulses;
  logic [TW-1:0]     tmr;
  logic              pass_q, fail_q;
  logic [1:0]        code_q;

  assign busy       = (st != S_IDLE);
  assign vpp_en     = busy;
  assign pass       = pass_q;
  assign fail       = fail_q;
  assign fail_code  = code_q;
  assign last_addr  = addr;
  assign prog_start = (st == S_PRE);
  assign prog_addr  = addr;
  assign bus_req    = (st == S_SET1) || (st == S_SET2) || (st == S_VCMD) ||
                      (st == S_VRD)  || (st == S_RDCMD);
  assign bus_we     = (st != S_VRD);
  assign bus_addr   = addr;
  assign bus_wdata  = (st == S_VCMD)  ? CMD_VERIFY :
                      (st == S_RDCMD) ? CMD_READ   : CMD_ERASE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr   <= '0;
      pulses <= '0;
      tmr    <= '0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      code_q <= 2'b00;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          addr   <= '0;
          pulses <= '0;
          pass_q <= 1'b0;
          fail_q <= 1'b0;
          code_q <= 2'b00;
          st     <= S_PRE;
        end
        S_PRE: st <= S_PREW;
        S_PREW: if (prog_done) begin
          if (prog_fail) begin
            fail_q <= 1'b1;
            code_q <= 2'b01;
            st     <= S_IDLE;
          end else if (addr == LAST) begin
            addr <= '0;
            st   <= S_SET1;
          end else begin
            addr <= addr + 1'b1;
            st   <= S_PRE;
          end
        end
        S_SET1: if (bus_ack) st <= S_SET2;
        S_SET2: if (bus_ack) begin
          pulses <= pulses + 1'b1;
          tmr    <= TW'(ERASE_CYC - 1);
          st     <= S_PULSE;
        end
        S_PULSE, S_VWAIT: begin
          if (tmr == '0) st <= (st == S_PULSE) ? S_VCMD : S_VRD;
          else           tmr <= tmr - 1'b1;
        end
        S_VCMD: if (bus_ack) begin
          tmr <= TW'(VERIFY_CYC - 1);
          st  <= S_VWAIT;
        end
        S_VRD: if (bus_ack) begin
          if (bus_rdata == 8'hFF) begin
            if (addr == LAST) st <= S_RDCMD;
            else begin
              addr <= addr + 1'b1;
              st   <= S_VCMD;
            end
          end else if (pulses == PW'(MAX_PULSES)) begin
            fail_q <= 1'b1;
            code_q <= 2'b10;
            st     <= S_IDLE;
          end else begin
            st <= S_SET1;
          end
        end
        S_RDCMD: if (bus_ack) begin
          pass_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
  parameter int ADDR_W    = 16,
  parameter int LAST_ADDR = 'hFFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              pass,
  input logic              fail,
  input logic [1:0]        fail_code,
  input logic [ADDR_W-1:0] last_addr,
  input logic              vpp_en,
  input logic              prog_start,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_ack
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req && !prog_start);

  p_prog_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  p_vpp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req || prog_start) |-> vpp_en);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

  p_pass_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> !busy && !fail && last_addr == LAST_ADDR[ADDR_W-1:0]);

  p_fail_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> !busy && !pass && fail_code != 2'b00);
endmodule

bind flash_erase_seq flash_erase_seq_chk #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .pass(pass), .fail(fail),
  .fail_code(fail_code), .last_addr(last_addr), .vpp_en(vpp_en),
  .prog_start(prog_start), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack));

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
  localparam int AW = 16, NA = 8, MAXP = 3, ECYC = 40, VCYC = 6;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, pass, fail, vpp_en, prog_start, prog_done, prog_fail;
  logic bus_req, bus_we, bus_ack;
  logic [1:0] fail_code;
  logic [AW-1:0] last_addr, prog_addr, bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  always #2 clk = ~clk;

  flash_erase_seq #(.ADDR_W(AW), .LAST_ADDR(NA-1), .MAX_PULSES(MAXP),
                    .ERASE_CYC(ECYC), .VERIFY_CYC(VCYC)) u_dut (.*);

  int checks = 0, errors = 0;
  logic [23:0] nvec = '0;
  int fail_at = NA;
  logic clr = 0;

  int n20, npulse, nreads, n00, perr, prog_calls, idle_cnt, need_idle, pdly;
  logic pair_pend;
  logic [7:0] last_wr;
  logic [AW-1:0] vaddr, paddr;

  assign bus_rdata = (npulse >= int'(nvec[bus_addr[2:0]*3 +: 3])) ? 8'hFF : 8'h00;

  always @(posedge clk) begin
    if (!rst_n) bus_ack <= 0;
    else        bus_ack <= bus_req && !bus_ack;
  end

  always @(posedge clk) begin
    if (clr) begin
      n20 <= 0; npulse <= 0; nreads <= 0; n00 <= 0; perr <= 0; prog_calls <= 0;
      idle_cnt <= 0; need_idle <= 0; pair_pend <= 0; last_wr <= 8'h00; vaddr <= '0;
      pdly <= 0; prog_done <= 0; prog_fail <= 0; paddr <= '0;
    end else begin
      if ((bus_req || prog_start) && !vpp_en) perr <= perr + 1;
      if (prog_start) begin
        if (int'(prog_addr) != prog_calls) perr <= perr + 1;
        prog_calls <= prog_calls + 1;
        paddr <= prog_addr;
        pdly <= 2;
      end else if (pdly > 0) pdly <= pdly - 1;
      prog_done <= (pdly == 1);
      prog_fail <= (pdly == 1) && (int'(paddr) == fail_at);
      if (!bus_req) idle_cnt <= idle_cnt + 1;
      if (bus_req && bus_ack) begin
        if (idle_cnt < need_idle) perr <= perr + 1;
        idle_cnt <= 0;
        need_idle <= 0;
        if (bus_we) begin
          last_wr <= bus_wdata;
          if (bus_wdata == 8'h20) begin
            if (prog_calls != NA) perr <= perr + 1;
            n20 <= n20 + 1;
            if (pair_pend) begin
              npulse <= npulse + 1; pair_pend <= 0; need_idle <= ECYC;
            end else pair_pend <= 1;
          end else begin
            if (pair_pend) perr <= perr + 1;
            if (bus_wdata == 8'hA0) begin vaddr <= bus_addr; need_idle <= VCYC; end
            if (bus_wdata == 8'h00) n00 <= n00 + 1;
          end
        end else begin
          nreads <= nreads + 1;
          if (last_wr != 8'hA0 || bus_addr != vaddr) perr <= perr + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [23:0] nv, input int fa, input bit restart);
    @(negedge clk);
    nvec = nv; fail_at = fa; clr = 1;
    @(negedge clk);
    clr = 0; start = 1;
    @(negedge clk);
    start = 0;
    if (restart) begin
      repeat (30) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    for (int w = 0; w < 20000 && busy; w++) @(negedge clk);
    chk(!busy, "watchdog", busy, 0);
    @(negedge clk);
  endtask

  // need(24, octal digit per address, addr0 lowest), pass, last addr, pulses, reads
  localparam logic [39:0] VEC [6] = '{
    {24'o11111111, 1'b1, 3'd7, 4'd1, 8'd8},
    {24'o11112111, 1'b1, 3'd7, 4'd2, 8'd9},
    {24'o11311211, 1'b1, 3'd7, 4'd3, 8'd10},
    {24'o14111111, 1'b0, 3'd6, 4'd3, 8'd9},
    {24'o21111113, 1'b1, 3'd7, 4'd3, 8'd10},
    {24'o31111111, 1'b1, 3'd7, 4'd3, 8'd10}
  };

  initial begin
    clr = 1;
    repeat (3) @(negedge clk);
    rst_n = 1; clr = 0;
    @(negedge clk);
    chk(!busy && !pass && !fail && !vpp_en, "R1 idle", {busy, pass, fail, vpp_en}, 0);
    chk(fail_code == 0 && !bus_req && !prog_start, "R1 quiet", fail_code, 0);

    for (int i = 0; i < 6; i++) begin
      run(VEC[i][39:16], NA, 1'b0);
      chk(pass == VEC[i][15] && fail == !VEC[i][15], VEC[i][15] ? "R9 pass" : "R8 fail",
          pass, VEC[i][15]);
      chk(fail_code == (VEC[i][15] ? 2'b00 : 2'b10), "R8 code", fail_code, VEC[i][15] ? 0 : 2);
      chk(int'(last_addr) == int'(VEC[i][14:12]), "R8/R9 last_addr", last_addr, VEC[i][14:12]);
      chk(npulse == int'(VEC[i][11:8]) && n20 == 2 * npulse, "R4 pulses", npulse, VEC[i][11:8]);
      chk(nreads == int'(VEC[i][7:0]), "R6/R7 reads", nreads, VEC[i][7:0]);
      chk(n00 == int'(VEC[i][15]), "R9 read cmd", n00, VEC[i][15]);
      chk(prog_calls == NA, "R2 precondition", prog_calls, NA);
      chk(perr == 0, "R5/R11 protocol", perr, 0);
      chk(!vpp_en, "R10 vpp off", vpp_en, 0);
    end

    run(24'o11111111, 4, 1'b0);
    chk(fail && fail_code == 2'b01, "R3 code", fail_code, 1);
    chk(last_addr == 4, "R3 addr", last_addr, 4);
    chk(prog_calls == 5 && n20 == 0 && nreads == 0, "R3 no erase", n20, 0);
    chk(!vpp_en && perr == 0, "R10 after R3", perr, 0);

    run(24'o11112111, NA, 1'b1);
    chk(pass && prog_calls == NA, "R12 start ignored", prog_calls, NA);
    chk(nreads == 9 && npulse == 2, "R12 single run", nreads, 9);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule